// File: doc/BRIEF.md
# Fully Associative Page Translation Buffer

This block caches virtual-to-physical page mappings for a memory pipeline. A 32-bit virtual address comes in on a valid/ready request channel. The virtual page number in bits 31:12 is compared in parallel against all 64 stored tags. The frame number of the matching entry is joined to the untouched 12-bit page offset to form a 28-bit physical address. The result leaves on a valid/ready response channel one cycle after the request is accepted. The response is marked as a hit, a miss, or a permission fault. Each entry has its own read and write permission, and these are tested against the access type of the request.

Entries are managed through plain control pins. A fill writes a new mapping. A single-page invalidate removes every entry with a given page number. A flush removes every entry that is not locked. A locked entry stays in place through flushes and is never chosen as a victim for replacement.

Back-pressure rules:
- A request is accepted on a clock edge where both `lk_valid` and `lk_ready` are high.
- `lk_ready` is high whenever no response is pending, or when the pending response is consumed in the same cycle.
- A response that is not consumed keeps its value until `rs_ready` is seen high.

Top module: `xlat_buf`

## Requirements
- R1: When an accepted request matches a valid entry, and the permission for its access type is set, the response arrives on the next cycle. It has `rs_hit`=1 and `rs_paddr` = {stored 16-bit frame, request bits 11:0}, with the frame in bits 27:12.
- R2: A request that matches no valid entry gives `rs_miss`=1 and `rs_paddr`=0.
- R3: A read (`lk_write`=0) needs the entry's read permission, and a write (`lk_write`=1) needs its write permission. When the needed permission is clear, the response is `rs_fault`=1 with `rs_hit`=0 and `rs_paddr`=0.
- R4: When several valid entries hold the same page number, the entry with the lowest index supplies the translation.
- R5: A fill writes the lowest-index invalid entry, whenever at least one entry is invalid.
- R6: When every entry is valid, a fill replaces the first unlocked entry found by scanning upward (with wrap) from a victim pointer. The pointer is 0 after reset, and after each such replacement it moves to the slot after the victim. A fill is dropped when all entries are valid and locked.
- R7: A flush (`flush_all`) invalidates every unlocked entry in one cycle. Locked entries keep translating.
- R8: A single-page invalidate clears every valid entry whose tag equals `inv_vpn`, whether locked or not.
- R9: When more than one maintenance command is asserted in the same cycle, only one takes effect. The order is flush, then invalidate, then fill; the commands of lower rank are dropped.
- R10: `lk_ready` is low while a response is held with `rs_ready` low. A held response keeps all its outputs stable.
- R11: After reset `rs_valid` is 0 and the table is empty. While `rs_valid` is 1, exactly one of `rs_hit`, `rs_miss`, `rs_fault` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request can be accepted |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_write | input | 1 | Access type: 1 = write, 0 = read |
| rs_valid | output | 1 | Response valid |
| rs_ready | input | 1 | Response consumer ready |
| rs_hit | output | 1 | Translation succeeded |
| rs_miss | output | 1 | No valid matching entry |
| rs_fault | output | 1 | Matching entry forbids the access |
| rs_paddr | output | 28 | Physical address, zero unless hit |
| fill_en | input | 1 | Write a new mapping |
| fill_vpn | input | 20 | Page number of the new mapping |
| fill_pfn | input | 16 | Frame number of the new mapping |
| fill_rd | input | 1 | Read permission of the new mapping |
| fill_wr | input | 1 | Write permission of the new mapping |
| fill_lock | input | 1 | Lock the new mapping |
| inv_en | input | 1 | Invalidate entries with tag `inv_vpn` |
| inv_vpn | input | 20 | Page number to invalidate |
| flush_all | input | 1 | Invalidate all unlocked entries |

## Verification
The assertions assume that a producer keeps presenting a request until it is accepted, and that the consumer may pull `rs_ready` low at any time. The stability checks therefore only judge the block's own outputs while a response is held. The bench drives every input half a clock away from the active edge. It changes the request address while a response is held, to show that the held response does not move. Apart from the one priority scenario, the bench issues maintenance commands one at a time.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [1:0] {
    RK_MISS  = 2'd0,
    RK_HIT   = 2'd1,
    RK_FAULT = 2'd2
  } resp_kind_t;
endpackage

// File: rtl/xlat_match.sv
module xlat_match #(
  parameter int N     = 64,
  parameter int VPN_W = 20
) (
  input  logic [N-1:0]            vld,
  input  logic [N-1:0][VPN_W-1:0] tag,
  input  logic [VPN_W-1:0]        key,
  output logic [N-1:0]            hit_vec
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit_vec[i] = vld[i] && (tag[i] == key);
  end
endmodule

// File: rtl/xlat_pick.sv
module xlat_pick #(
  parameter int N = 64,
  parameter int W = 18,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]        req,
  input  logic [N-1:0][W-1:0] data,
  output logic                any,
  output logic [W-1:0]        dout
);
  logic [IDX_W-1:0] idx;
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (!any && req[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
  assign dout = data[idx];
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int N = 64,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vld,
  input  logic [N-1:0]     lck,
  input  logic [IDX_W-1:0] rr,
  output logic [IDX_W-1:0] slot,
  output logic             ok,
  output logic             use_rr
);
  logic             free_found, rr_found;
  logic [IDX_W-1:0] free_idx, rr_idx, j;

  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = 0; i < N; i++) begin
      if (!free_found && !vld[i]) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
    end
    rr_found = 1'b0;
    rr_idx   = '0;
    j        = '0;
    for (int k = 0; k < N; k++) begin
      j = rr + IDX_W'(k);
      if (!rr_found && !lck[j]) begin
        rr_found = 1'b1;
        rr_idx   = j;
      end
    end
  end

  assign use_rr = !free_found;
  assign ok     = free_found || rr_found;
  assign slot   = free_found ? free_idx : rr_idx;
endmodule

// File: rtl/xlat_buf.sv
module xlat_buf #(
  parameter int N      = 64,
  parameter int VA_W   = 32,
  parameter int PA_W   = 28,
  parameter int OFF_W  = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  lk_valid,
  output logic                  lk_ready,
  input  logic [VA_W-1:0]       lk_vaddr,
  input  logic                  lk_write,
  output logic                  rs_valid,
  input  logic                  rs_ready,
  output logic                  rs_hit,
  output logic                  rs_miss,
  output logic                  rs_fault,
  output logic [PA_W-1:0]       rs_paddr,
  input  logic                  fill_en,
  input  logic [VA_W-OFF_W-1:0] fill_vpn,
  input  logic [PA_W-OFF_W-1:0] fill_pfn,
  input  logic                  fill_rd,
  input  logic                  fill_wr,
  input  logic                  fill_lock,
  input  logic                  inv_en,
  input  logic [VA_W-OFF_W-1:0] inv_vpn,
  input  logic                  flush_all
);
  import xlat_pkg::*;

  localparam int IDX_W = $clog2(N);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PFN_W = PA_W - OFF_W;
  localparam int DW    = PFN_W + 2;

  // table storage
  logic [N-1:0]            vld_q, lck_q;
  logic [N-1:0][VPN_W-1:0] tag_q;
  logic [N-1:0][DW-1:0]    dat_q;   // {rd, wr, pfn}
  logic [IDX_W-1:0]        rr_q;

  // lookup path
  logic [N-1:0]  hv;
  logic          any_hit;
  logic [DW-1:0] sel;
  logic          perm_ok;
  logic          lk_acc;

  xlat_match #(.N(N), .VPN_W(VPN_W)) u_match (
    .vld(vld_q), .tag(tag_q), .key(lk_vaddr[VA_W-1:OFF_W]), .hit_vec(hv)
  );

  xlat_pick #(.N(N), .W(DW)) u_pick (
    .req(hv), .data(dat_q), .any(any_hit), .dout(sel)
  );

  assign perm_ok  = lk_write ? sel[PFN_W] : sel[PFN_W+1];
  assign lk_ready = !rs_valid || rs_ready;
  assign lk_acc   = lk_valid && lk_ready;

  resp_kind_t       kind_q;
  logic [PA_W-1:0]  paddr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          rs_valid <= 1'b0;
    else if (lk_acc)     rs_valid <= 1'b1;
    else if (rs_ready)   rs_valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind_q  <= RK_MISS;
      paddr_q <= '0;
    end else if (lk_acc) begin
      if (!any_hit) begin
        kind_q  <= RK_MISS;
        paddr_q <= '0;
      end else if (!perm_ok) begin
        kind_q  <= RK_FAULT;
        paddr_q <= '0;
      end else begin
        kind_q  <= RK_HIT;
        paddr_q <= {sel[PFN_W-1:0], lk_vaddr[OFF_W-1:0]};
      end
    end
  end

  assign rs_hit   = rs_valid && (kind_q == RK_HIT);
  assign rs_miss  = rs_valid && (kind_q == RK_MISS);
  assign rs_fault = rs_valid && (kind_q == RK_FAULT);
  assign rs_paddr = paddr_q;

  // maintenance path
  logic [IDX_W-1:0] vslot;
  logic             vok, vuse_rr, fill_go;

  xlat_victim #(.N(N)) u_victim (
    .vld(vld_q), .lck(lck_q), .rr(rr_q), .slot(vslot), .ok(vok), .use_rr(vuse_rr)
  );

  assign fill_go = fill_en && !flush_all && !inv_en && vok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      lck_q <= '0;
      rr_q  <= '0;
    end else if (flush_all) begin
      vld_q <= vld_q & lck_q;
    end else if (inv_en) begin
      for (int i = 0; i < N; i++) begin
        if (vld_q[i] && tag_q[i] == inv_vpn) begin
          vld_q[i] <= 1'b0;
          lck_q[i] <= 1'b0;
        end
      end
    end else if (fill_go) begin
      vld_q[vslot] <= 1'b1;
      lck_q[vslot] <= fill_lock;
      if (vuse_rr) rr_q <= vslot + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_go) begin
      tag_q[vslot] <= fill_vpn;
      dat_q[vslot] <= {fill_rd, fill_wr, fill_pfn};
    end
  end
endmodule

// File: rtl/xlat_buf_chk.sv
module xlat_buf_chk #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 28,
  parameter int OFF_W = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            lk_valid,
  input logic            lk_ready,
  input logic [VA_W-1:0] lk_vaddr,
  input logic            rs_valid,
  input logic            rs_ready,
  input logic            rs_hit,
  input logic            rs_miss,
  input logic            rs_fault,
  input logic [PA_W-1:0] rs_paddr
);
  // R11: exactly one outcome flag per response
  a_r11_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid |-> $onehot({rs_hit, rs_miss, rs_fault}));

  // R10: a held response does not move
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_ready) |=> (rs_valid && $stable(rs_paddr) && $stable({rs_hit, rs_miss, rs_fault})));

  // R10: an accepted request yields a response next cycle
  a_r10_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> rs_valid);

  // R2 and R3: non-hit responses carry a zero address
  a_r2_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_hit) |-> (rs_paddr == '0));

  // R1: offset passes through untranslated
  a_r1_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> (!rs_hit || rs_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0])));
endmodule

bind xlat_buf xlat_buf_chk #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_chk (.*);

// File: tb/xlat_buf_test.sv
module xlat_buf_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_valid, lk_ready, lk_write;
  logic [31:0] lk_vaddr;
  logic        rs_valid, rs_ready, rs_hit, rs_miss, rs_fault;
  logic [27:0] rs_paddr;
  logic        fill_en, fill_rd, fill_wr, fill_lock, inv_en, flush_all;
  logic [19:0] fill_vpn, inv_vpn;
  logic [15:0] fill_pfn;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xlat_buf uut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    lk_valid = 0; lk_write = 0; lk_vaddr = '0; rs_ready = 1;
    fill_en = 0; fill_rd = 0; fill_wr = 0; fill_lock = 0; fill_vpn = '0; fill_pfn = '0;
    inv_en = 0; inv_vpn = '0; flush_all = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle_inputs();
    rst_n = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic fill(logic [19:0] vpn, logic [15:0] pfn, logic rd, logic wr, logic lk);
    fill_en = 1; fill_vpn = vpn; fill_pfn = pfn; fill_rd = rd; fill_wr = wr; fill_lock = lk;
    @(negedge clk);
    fill_en = 0;
  endtask

  task automatic inval(logic [19:0] vpn);
    inv_en = 1; inv_vpn = vpn;
    @(negedge clk);
    inv_en = 0;
  endtask

  task automatic flush();
    flush_all = 1;
    @(negedge clk);
    flush_all = 0;
  endtask

  // returns {hit, miss, fault} and paddr sampled one cycle after acceptance
  task automatic look(logic [31:0] va, logic wr, output logic [2:0] flg, output logic [27:0] pa);
    lk_valid = 1; lk_vaddr = va; lk_write = wr;
    @(negedge clk);
    lk_valid = 0;
    flg = {rs_hit, rs_miss, rs_fault};
    pa  = rs_paddr;
  endtask

  task automatic t_reset();
    logic [2:0] f; logic [27:0] p;
    do_reset();
    check("R11 reset rs_valid", rs_valid, 0);
    check("R10 reset lk_ready", lk_ready, 1);
    look(32'h0000_1000, 0, f, p);
    check("R2 empty table miss", f, 3'b010);
    check("R2 miss paddr zero", p, 0);
  endtask

  task automatic t_hit_and_perm();
    logic [2:0] f; logic [27:0] p;
    do_reset();
    fill(20'h00ABC, 16'h1234, 1, 0, 0);
    look(32'h00AB_C5A7, 0, f, p);
    check("R1 read hit flags", f, 3'b100);
    check("R1 read hit paddr", p, 28'h12345A7);
    look(32'h00AB_C5A7, 1, f, p);
    check("R3 write fault flags", f, 3'b001);
    check("R3 fault paddr zero", p, 0);
    fill(20'h00DEF, 16'hBEEF, 0, 1, 0);
    look(32'h00DE_F001, 0, f, p);
    check("R3 read fault flags", f, 3'b001);
    look(32'h00DE_FFFF, 1, f, p);
    check("R1 write hit paddr", p, 28'hBEEFFFF);
    look(32'h00DE_E000, 0, f, p);
    check("R2 neighbour page miss", f, 3'b010);
  endtask

  task automatic t_dup_and_free_slot();
    logic [2:0] f; logic [27:0] p;
    do_reset();
    fill(20'h00011, 16'h0001, 1, 1, 0);   // slot 0
    fill(20'h00022, 16'h0002, 1, 1, 0);   // slot 1
    fill(20'h00022, 16'h0003, 1, 1, 0);   // slot 2, duplicate tag
    look(32'h0002_2000, 0, f, p);
    check("R4 lowest index wins", p, 28'h0002000);
    inval(20'h00011);                     // frees slot 0
    look(32'h0001_1000, 0, f, p);
    check("R8 invalidated page misses", f, 3'b010);
    fill(20'h00022, 16'h0009, 1, 1, 0);   // must land in slot 0
    look(32'h0002_2010, 0, f, p);
    check("R5 fill uses lowest free slot", p, 28'h0009010);
    inval(20'h00022);
    look(32'h0002_2000, 0, f, p);
    check("R8 all duplicates cleared", f, 3'b010);
  endtask

  task automatic t_lock_flush();
    logic [2:0] f; logic [27:0] p;
    do_reset();
    fill(20'h00100, 16'h0100, 1, 1, 1);
    fill(20'h00200, 16'h0200, 1, 1, 0);
    flush();
    look(32'h0010_0004, 0, f, p);
    check("R7 locked survives flush", p, 28'h0100004);
    look(32'h0020_0004, 0, f, p);
    check("R7 unlocked flushed", f, 3'b010);
    inval(20'h00100);
    look(32'h0010_0004, 0, f, p);
    check("R8 invalidate clears locked", f, 3'b010);
  endtask

  task automatic t_round_robin();
    logic [2:0] f; logic [27:0] p;
    do_reset();
    fill(20'h00100, 16'h0100, 1, 1, 1);   // slot 0 locked
    for (int i = 1; i < 64; i++) fill(20'h00100 + 20'(i), 16'h0100 + 16'(i), 1, 1, 0);
    fill(20'h00900, 16'h0900, 1, 1, 0);   // replaces slot 1
    look(32'h0010_1000, 0, f, p);
    check("R6 first victim evicted", f, 3'b010);
    look(32'h0090_0000, 0, f, p);
    check("R6 new mapping hits", p, 28'h0900000);
    fill(20'h00A00, 16'h0A00, 1, 1, 0);   // replaces slot 2
    look(32'h0010_2000, 0, f, p);
    check("R6 pointer advanced", f, 3'b010);
    look(32'h0010_3000, 0, f, p);
    check("R6 next entry untouched", p, 28'h0103000);
    look(32'h0010_0000, 0, f, p);
    check("R6 locked never replaced", p, 28'h0100000);
  endtask

  task automatic t_priority();
    logic [2:0] f; logic [27:0] p;
    do_reset();
    fill(20'h00300, 16'h0300, 1, 1, 0);
    inv_en = 1; inv_vpn = 20'h00300;
    fill(20'h00400, 16'h0400, 1, 1, 0);   // same cycle as invalidate
    inv_en = 0;
    look(32'h0040_0000, 0, f, p);
    check("R9 fill dropped under invalidate", f, 3'b010);
    look(32'h0030_0000, 0, f, p);
    check("R9 invalidate applied", f, 3'b010);
    fill(20'h00500, 16'h0500, 1, 1, 1);
    flush_all = 1; inv_en = 1; inv_vpn = 20'h00500;
    @(negedge clk);
    flush_all = 0; inv_en = 0;
    look(32'h0050_0000, 0, f, p);
    check("R9 invalidate dropped under flush", p, 28'h0500000);
  endtask

  task automatic t_backpressure();
    logic [2:0] f; logic [27:0] p;
    do_reset();
    fill(20'h00777, 16'h0777, 1, 1, 0);
    rs_ready = 0;
    look(32'h0077_7123, 0, f, p);
    check("R10 response valid", rs_valid, 1);
    check("R10 not ready while held", lk_ready, 0);
    lk_valid = 1; lk_vaddr = 32'h0088_8000; lk_write = 0;
    @(negedge clk);
    check("R10 held paddr stable", rs_paddr, 28'h0777123);
    check("R10 held flags stable", {rs_hit, rs_miss, rs_fault}, 3'b100);
    rs_ready = 1;
    @(negedge clk);
    lk_valid = 0;
    check("R2 queued request answered", {rs_hit, rs_miss, rs_fault}, 3'b010);
    @(negedge clk);
    check("R10 response drained", rs_valid, 0);
  endtask

  initial begin
    idle_inputs();
    rst_n = 0;
    t_reset();
    t_hit_and_perm();
    t_dup_and_free_slot();
    t_lock_flush();
    t_round_robin();
    t_priority();
    t_backpressure();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule